// File: doc/BRIEF.md
# Per-Lane Buffer Address Generator

This block turns one vector buffer access into a memory address for each lane of a wide vector. A buffer descriptor supplies the base address, the record stride, the record count, a flag that adds the lane number to the index, a data-format field that widens the stride when that flag is set, a swizzle enable, and two small codes that set the swizzle tile sizes. Each lane brings its own index and byte offset. A scalar offset and an instruction immediate apply to all lanes. The execution mask selects the lanes that take part.

The block visits one lane per clock cycle. It writes that lane's address, its out-of-bounds bit and its effective-mask bit into output registers. The effective mask is the execution mask with the out-of-bounds lanes cleared, so the memory stage downstream can use it directly. A start pulse begins a pass. All inputs must stay unchanged until the one-cycle done pulse. Two addressing layouts are supported: a linear layout (offset plus stride times index) and a swizzled layout. The swizzled layout interleaves small tiles of indices and elements. Each layout has its own out-of-bounds rule.

Top module: `bufaddr_lane_gen`

## Requirements
- R1: While reset is asserted and after it is released, busy_o and done_o are low and every addr_o lane, oob_o bit and eff_o bit is zero.
- R2: A start_i pulse sampled while idle sets busy_o from the next edge. Lane k is written at the (k+1)-th edge after the start edge. done_o is high for exactly one cycle, on the LANES-th edge after the start edge, and busy_o falls on that same edge.
- R3: start_i is ignored while busy_o is high: the pass ends on its original schedule and does not restart.
- R4: The effective stride is stride_i. When tid_en_i is 1 it is instead (dfmt_i shifted left by 14) plus stride_i. The lane index is the lane's lane_idx_i field (bits [32k+31:32k]), plus the lane number k when tid_en_i is 1.
- R5: The lane offset is the lane's lane_off_i field (bits [32k+31:32k]) plus imm_i.
- R6: With swz_en_i = 0, the buffer offset is lane offset + effective stride × lane index. The lane address (addr_o bits [48k+47:48k]) is base_i + soff_i + buffer offset, modulo 2^48.
- R7: With swz_en_i = 1, let T = 8 << idx_code_i and E = 2 << esz_code_i. The index splits into quotient and remainder by T, and the offset splits into quotient and remainder by E. The buffer offset is (index quotient × effective stride + offset quotient × E) × T + index remainder × E + offset remainder.
- R8: When stride_i is zero or swz_en_i is 0, an active lane is out of bounds when (lane offset + effective stride × lane index) + soff_i ≥ nrec_i. This sum is taken without wrap, so a soff_i above nrec_i puts every active lane out of bounds.
- R9: When stride_i is nonzero and swz_en_i is 1, an active lane is out of bounds when its index ≥ nrec_i or its offset ≥ the effective stride.
- R10: A lane whose exec_i bit is 0 ends the pass with a zero address, oob_o bit 0 and eff_o bit 0.
- R11: An out-of-bounds lane ends the pass with a zero address, oob_o bit 1 and eff_o bit 0. An in-bounds active lane has eff_o bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a pass when idle |
| base_i | input | 48 | Descriptor base address |
| stride_i | input | 14 | Descriptor stride |
| nrec_i | input | 32 | Descriptor record count |
| tid_en_i | input | 1 | Add lane number to index and widen the stride |
| dfmt_i | input | 4 | Data-format field, folded into the stride when tid_en_i is 1 |
| swz_en_i | input | 1 | Swizzled layout enable |
| idx_code_i | input | 2 | Index tile code, T = 8 << code |
| esz_code_i | input | 2 | Element size code, E = 2 << code |
| soff_i | input | 32 | Scalar offset |
| imm_i | input | 12 | Instruction immediate offset |
| lane_idx_i | input | LANES*32 | Per-lane index, lane k at [32k+31:32k] |
| lane_off_i | input | LANES*32 | Per-lane offset, lane k at [32k+31:32k] |
| exec_i | input | LANES | Execution mask |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| addr_o | output | LANES*48 | Per-lane address, lane k at [48k+47:48k] |
| oob_o | output | LANES | Out-of-bounds mask |
| eff_o | output | LANES | Execution mask with out-of-bounds lanes removed |

## Verification
The bench compares every lane against its own model in four layouts: linear and swizzled, each with and without the lane-number fold. Lane data is chosen so that some lanes land just inside the record limit and some just outside. If a design used the plain stride in place of the widened one, or forgot the lane number, the addresses would be off by a lane-dependent amount. A swizzle with the quotient and remainder swapped, or with an off-by-one tile size, would scramble only the lanes whose index crosses a tile edge. A descriptor with a zero stride and swizzle enabled must fall back to the linear bounds rule, and a scalar offset above the record count must reject every lane rather than wrap. Both would go wrong in a design that chose the rule from the swizzle bit alone or subtracted without widening. A partial execution mask and a start pulse issued mid-pass check that idle lanes stay zero and that the pass is not restarted.

// File: rtl/bufaddr_pkg.sv
package bufaddr_pkg;
  localparam int AW       = 48;
  localparam int STRIDE_W = 14;
  localparam int NREC_W   = 32;
  localparam int DFMT_W   = 4;
  localparam int CODE_W   = 2;
  localparam int IDX_W    = 32;
  localparam int OFF_W    = 32;
  localparam int SOFF_W   = 32;
  localparam int IMM_W    = 12;
  localparam int DFMT_SH  = 14;

  typedef struct packed {
    logic [AW-1:0]       base;
    logic [STRIDE_W-1:0] stride;
    logic [NREC_W-1:0]   nrec;
    logic                tid_en;
    logic [DFMT_W-1:0]   dfmt;
    logic                swz_en;
    logic [CODE_W-1:0]   idx_code;
    logic [CODE_W-1:0]   esz_code;
  } desc_t;
endpackage

// File: rtl/bufaddr_lane_calc.sv
module bufaddr_lane_calc
  import bufaddr_pkg::*;
#(
  parameter int LW = 6
) (
  input  desc_t             desc,
  input  logic [SOFF_W-1:0] soff,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  lidx,
  input  logic [OFF_W-1:0]  loff,
  input  logic [LW-1:0]     lane,
  input  logic              act,
  output logic [AW-1:0]     addr,
  output logic              oob,
  output logic              eff
);
  logic [AW-1:0] es_w, idx_w, off_w;
  logic [2:0]    sh_i, sh_e;
  logic [AW-1:0] idx_q, idx_r, off_q, off_r;
  logic [AW-1:0] lin_bo, swz_bo, bo;
  logic          lin_oob, swz_oob, use_lin;

  always_comb begin
    es_w  = desc.tid_en ? ((AW'(desc.dfmt) << DFMT_SH) + AW'(desc.stride))
                        : AW'(desc.stride);
    idx_w = AW'(lidx) + (desc.tid_en ? AW'(lane) : '0);
    off_w = AW'(loff) + AW'(imm);

    sh_i  = 3'd3 + {1'b0, desc.idx_code};
    sh_e  = 3'd1 + {1'b0, desc.esz_code};
    idx_q = idx_w >> sh_i;
    idx_r = idx_w & ((AW'(1) << sh_i) - AW'(1));
    off_q = off_w >> sh_e;
    off_r = off_w & ((AW'(1) << sh_e) - AW'(1));

    lin_bo = off_w + es_w * idx_w;
    swz_bo = ((idx_q * es_w + (off_q << sh_e)) << sh_i) + (idx_r << sh_e) + off_r;
    bo     = desc.swz_en ? swz_bo : lin_bo;

    lin_oob = ({1'b0, lin_bo} + (AW+1)'(soff)) >= (AW+1)'(desc.nrec);
    swz_oob = (idx_w >= AW'(desc.nrec)) || (off_w >= es_w);
    use_lin = (desc.stride == '0) || !desc.swz_en;

    oob  = act && (use_lin ? lin_oob : swz_oob);
    eff  = act && !oob;
    addr = eff ? (desc.base + AW'(soff) + bo) : '0;
  end
endmodule

// File: rtl/bufaddr_seq.sv
module bufaddr_seq #(
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] cnt
);
  logic          busy_n, done_n;
  logic [LW-1:0] cnt_n;

  always_comb begin
    busy_n = busy;
    done_n = 1'b0;
    cnt_n  = cnt;
    if (busy) begin
      if (cnt == LW'(LANES-1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt + LW'(1);
      end
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_n;
      done <= done_n;
      cnt  <= cnt_n;
    end
  end
endmodule

// File: rtl/bufaddr_lane_gen.sv
module bufaddr_lane_gen
  import bufaddr_pkg::*;
#(
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [AW-1:0]         base_i,
  input  logic [STRIDE_W-1:0]   stride_i,
  input  logic [NREC_W-1:0]     nrec_i,
  input  logic                  tid_en_i,
  input  logic [DFMT_W-1:0]     dfmt_i,
  input  logic                  swz_en_i,
  input  logic [CODE_W-1:0]     idx_code_i,
  input  logic [CODE_W-1:0]     esz_code_i,
  input  logic [SOFF_W-1:0]     soff_i,
  input  logic [IMM_W-1:0]      imm_i,
  input  logic [LANES*IDX_W-1:0] lane_idx_i,
  input  logic [LANES*OFF_W-1:0] lane_off_i,
  input  logic [LANES-1:0]      exec_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [LANES*AW-1:0]   addr_o,
  output logic [LANES-1:0]      oob_o,
  output logic [LANES-1:0]      eff_o
);
  desc_t          desc;
  logic [LW-1:0]  lane_cnt;
  logic [AW-1:0]  c_addr;
  logic           c_oob, c_eff;
  logic [AW-1:0]  addr_q [LANES];
  logic [LANES-1:0] oob_q, eff_q;

  always_comb begin
    desc.base     = base_i;
    desc.stride   = stride_i;
    desc.nrec     = nrec_i;
    desc.tid_en   = tid_en_i;
    desc.dfmt     = dfmt_i;
    desc.swz_en   = swz_en_i;
    desc.idx_code = idx_code_i;
    desc.esz_code = esz_code_i;
  end

  bufaddr_seq #(.LANES(LANES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_o),
    .done  (done_o),
    .cnt   (lane_cnt)
  );

  bufaddr_lane_calc #(.LW(LW)) u_calc (
    .desc (desc),
    .soff (soff_i),
    .imm  (imm_i),
    .lidx (lane_idx_i[lane_cnt*IDX_W +: IDX_W]),
    .loff (lane_off_i[lane_cnt*OFF_W +: OFF_W]),
    .lane (lane_cnt),
    .act  (exec_i[lane_cnt]),
    .addr (c_addr),
    .oob  (c_oob),
    .eff  (c_eff)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wr_en;
    assign wr_en = busy_o && (lane_cnt == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        oob_q[g]  <= 1'b0;
        eff_q[g]  <= 1'b0;
      end else if (wr_en) begin
        addr_q[g] <= c_addr;
        oob_q[g]  <= c_oob;
        eff_q[g]  <= c_eff;
      end
    end

    assign addr_o[g*AW +: AW] = addr_q[g];
  end

  assign oob_o = oob_q;
  assign eff_o = eff_q;
endmodule

// File: rtl/bufaddr_lane_gen_chk.sv
module bufaddr_lane_gen_chk #(
  parameter int LANES = 64,
  parameter int AW = 48,
  localparam int LW = $clog2(LANES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [LW-1:0]       lane_cnt,
  input logic [LANES*AW-1:0] addr_o,
  input logic [LANES-1:0]    oob_o,
  input logic [LANES-1:0]    eff_o
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && lane_cnt != LW'(LANES-1)) |=> (busy_o && lane_cnt == $past(lane_cnt) + LW'(1)));
  // R11
  oob_not_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oob_o & eff_o) == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_zero
    // R10
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_o[g] |-> (addr_o[g*AW +: AW] == '0));
  end
endmodule

bind bufaddr_lane_gen bufaddr_lane_gen_chk #(.LANES(LANES), .AW(bufaddr_pkg::AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .lane_cnt (lane_cnt),
  .addr_o   (addr_o),
  .oob_o    (oob_o),
  .eff_o    (eff_o)
);

// File: tb/bufaddr_lane_gen_tb.sv
module bufaddr_lane_gen_tb;
  localparam int LANES = 64;
  localparam int AW = 48;
  localparam longint unsigned AMASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [AW-1:0] base_i;
  logic [13:0] stride_i;
  logic [31:0] nrec_i;
  logic tid_en_i;
  logic [3:0] dfmt_i;
  logic swz_en_i;
  logic [1:0] idx_code_i, esz_code_i;
  logic [31:0] soff_i;
  logic [11:0] imm_i;
  logic [LANES*32-1:0] lane_idx_i, lane_off_i;
  logic [LANES-1:0] exec_i;
  logic busy_o, done_o;
  logic [LANES*AW-1:0] addr_o;
  logic [LANES-1:0] oob_o, eff_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bufaddr_lane_gen #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .nrec_i(nrec_i), .tid_en_i(tid_en_i), .dfmt_i(dfmt_i),
    .swz_en_i(swz_en_i), .idx_code_i(idx_code_i), .esz_code_i(esz_code_i),
    .soff_i(soff_i), .imm_i(imm_i), .lane_idx_i(lane_idx_i), .lane_off_i(lane_off_i),
    .exec_i(exec_i), .busy_o(busy_o), .done_o(done_o), .addr_o(addr_o),
    .oob_o(oob_o), .eff_o(eff_o)
  );

  task automatic chk(input string req, input string what, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int lane, output longint unsigned a,
                                output bit o, output bit e);
    longint unsigned es, idx, off, ist, esz, bo, lin;
    bit r;
    es  = tid_en_i ? ((longint'(dfmt_i) << 14) + stride_i) : stride_i;
    idx = lane_idx_i[lane*32 +: 32] + (tid_en_i ? lane : 0);
    off = lane_off_i[lane*32 +: 32] + imm_i;
    lin = off + es * idx;
    if (swz_en_i) begin
      ist = 64'd8 << idx_code_i;
      esz = 64'd2 << esz_code_i;
      bo  = ((idx / ist) * es + (off / esz) * esz) * ist + (idx % ist) * esz + off % esz;
    end else bo = lin;
    if (stride_i == 0 || !swz_en_i) r = ((lin & AMASK) + soff_i) >= nrec_i;
    else r = (idx >= nrec_i) || (off >= es);
    o = exec_i[lane] && r;
    e = exec_i[lane] && !r;
    a = e ? ((base_i + soff_i + bo) & AMASK) : 0;
  endfunction

  task automatic fill(input int s1, input int m1, input int s2, input int m2);
    for (int k = 0; k < LANES; k++) begin
      lane_idx_i[k*32 +: 32] = 32'((k * 7 + s1) % m1);
      lane_off_i[k*32 +: 32] = 32'((k * 13 + s2) % m2);
    end
  endtask

  task automatic do_pass(input string tag);
    int n = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R2", {tag, " busy after start"}, busy_o, 1);
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R2", {tag, " done latency"}, n, LANES);
    chk("R2", {tag, " busy low at done"}, busy_o, 0);
  endtask

  task automatic compare(input string tag, input string areq, input string oreq);
    longint unsigned a;
    bit o, e;
    for (int k = 0; k < LANES; k++) begin
      model(k, a, o, e);
      chk(areq, $sformatf("%s lane %0d addr", tag, k), addr_o[k*AW +: AW], a);
      chk(oreq, $sformatf("%s lane %0d oob", tag, k), oob_o[k], o);
      chk(exec_i[k] ? "R11" : "R10", $sformatf("%s lane %0d eff", tag, k), eff_o[k], e);
    end
  endtask

  task automatic set_desc(input logic [13:0] st, input logic [31:0] nr, input logic tid,
                          input logic [3:0] df, input logic swz, input logic [1:0] ic,
                          input logic [1:0] ec, input logic [31:0] so, input logic [11:0] im);
    stride_i = st; nrec_i = nr; tid_en_i = tid; dfmt_i = df; swz_en_i = swz;
    idx_code_i = ic; esz_code_i = ec; soff_i = so; imm_i = im;
  endtask

  task automatic t_reset;
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "done in reset", done_o, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "oob after reset", oob_o, 0);
    chk("R1", "eff after reset", eff_o, 0);
    chk("R1", "addr lane 5 after reset", addr_o[5*AW +: AW], 0);
  endtask

  task automatic t_linear;
    base_i = 48'h1000; exec_i = '1;
    set_desc(14'd16, 32'd900, 1'b0, 4'd2, 1'b0, 2'd0, 2'd0, 32'd8, 12'd4);
    fill(3, 70, 1, 40);
    do_pass("linear");
    compare("linear", "R6", "R8");
    @(negedge clk);
    chk("R2", "done one cycle", done_o, 0);
  endtask

  task automatic t_linear_tid;
    base_i = 48'h20_0000_0000; exec_i = 64'hFFFF_0000_FFFF_FFFF;
    set_desc(14'd20, 32'h0010_0000, 1'b1, 4'd1, 1'b0, 2'd0, 2'd0, 32'd100, 12'd7);
    fill(0, 60, 5, 50);
    do_pass("linear tid");
    compare("linear tid", "R4", "R8");
  endtask

  task automatic t_swz;
    base_i = 48'h4000; exec_i = 64'hF0F0_F0F0_FF00_FF0F;
    set_desc(14'd24, 32'd60, 1'b0, 4'd3, 1'b1, 2'd1, 2'd2, 32'd12, 12'd3);
    fill(2, 75, 4, 30);
    do_pass("swizzle");
    compare("swizzle", "R7", "R9");
  endtask

  task automatic t_swz_tid;
    base_i = 48'h8_0000; exec_i = '1;
    set_desc(14'd6, 32'd80, 1'b1, 4'd0, 1'b1, 2'd0, 2'd0, 32'd0, 12'd1);
    fill(1, 40, 0, 7);
    do_pass("swizzle tid");
    compare("swizzle tid", "R5", "R9");
  endtask

  task automatic t_swz_zero_stride;
    base_i = 48'h100; exec_i = '1;
    set_desc(14'd0, 32'h0006_0000, 1'b1, 4'd1, 1'b1, 2'd2, 2'd1, 32'd16, 12'd2);
    fill(4, 9, 3, 20);
    do_pass("swizzle zero stride");
    compare("swizzle zero stride", "R7", "R8");
  endtask

  task automatic t_soff_over;
    base_i = 48'h100; exec_i = 64'h0F0F_0F0F_0F0F_0F0F;
    set_desc(14'd4, 32'd50, 1'b0, 4'd0, 1'b0, 2'd0, 2'd0, 32'd60, 12'd0);
    fill(0, 5, 0, 3);
    do_pass("soff over nrec");
    compare("soff over nrec", "R11", "R8");
    chk("R11", "soff over nrec oob mask", oob_o, 64'h0F0F_0F0F_0F0F_0F0F);
  endtask

  task automatic t_restart_ignored;
    int n = 0;
    base_i = 48'h300; exec_i = '1;
    set_desc(14'd8, 32'd10000, 1'b0, 4'd0, 1'b0, 2'd0, 2'd0, 32'd0, 12'd0);
    fill(5, 30, 2, 8);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 10) start_i = 1'b1;
      if (n == 11) start_i = 1'b0;
    end
    chk("R3", "done latency with mid-pass start", n, LANES);
    @(negedge clk);
    chk("R3", "no restart after done", busy_o, 0);
    compare("restart ignored", "R6", "R8");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; exec_i = '0;
    lane_idx_i = '0; lane_off_i = '0;
    set_desc('0, '0, 1'b0, '0, 1'b0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    t_reset;
    t_linear;
    t_linear_tid;
    t_swz;
    t_swz_tid;
    t_swz_zero_stride;
    t_soff_over;
    t_restart_ignored;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule